// File: doc/BRIEF.md
# Block-Aligned Pattern Recognizer

This block watches a stream of multi-bit symbols that arrives in consecutive blocks of `K` symbols. A symbol is taken only in a cycle where the check enable is high. The block raises `z` for one cycle when the symbol just taken closes a block and that symbol, together with the `K-1` taken before it, spells a fixed pattern. A pattern that is complete anywhere other than at a block boundary is ignored. An optional tally counts the blocks that matched, modulo `N`.

Two pieces of logic work side by side. A block sequencer tracks where the next taken symbol lands inside its block and flags the one that closes it. A sliding window holds the last `K-1` taken symbols and compares them, together with the current symbol, against the pattern. `z` is the AND of the two flags and is combinational from the current inputs. The sequencer has three named states. `SEQ_START`: the next symbol opens a block. `SEQ_BODY`: the next symbol is inside the block but does not close it. `SEQ_CLOSE`: the next symbol closes the block. Its transitions, each taken on an accepted symbol, are `open` (START to BODY, or to CLOSE when K=2, or back to START when K=1), `advance` (BODY to BODY), `near_end` (BODY to CLOSE) and `wrap` (CLOSE to START). The `restart` transition goes from any state to START on the initialize input. The pulse `init` clears the sequencer, the window and the tally, so that the next taken symbol is the first of a block.

Top module: `blkpat_recognizer`

## Requirements
- R1: After reset, `z` is 0 and `match_cnt` is 0.
- R2: An accepted symbol (`check`=1, `init`=0) closes a block when it is the K-th, 2K-th, 3K-th, ... accepted symbol since reset or the last `init`. `z` can be 1 only in such a cycle.
- R3: `z` is 1 exactly in a cycle where the current symbol closes a block and the last K accepted symbols, oldest first, equal `PATTERN`. `PATTERN` holds the oldest symbol in its most significant `SYM_W` bits and the newest in bits `[SYM_W-1:0]`. The default is 3,7,4 (`9'b011_111_100`).
- R4: A pattern occurrence that does not end on a block boundary gives no `z` and leaves `match_cnt` unchanged.
- R5: While `check` is 0, `z` is 0, the symbol is not taken, and neither the block position nor the window changes.
- R6: In a cycle with `init`=1, `z` is 0 and the symbol is dropped. From the next cycle on, the block position and the window are cleared and `match_cnt` is 0.
- R7: With `COUNT_EN`=1, `match_cnt` moves up by one in the cycle after each cycle with `z`=1. Otherwise it holds.
- R8: `match_cnt` counts modulo `N`: from `N-1` it steps to 0.
- R9: With K=3, 3-bit symbols and pattern 3,7,4, the stream 5 3 7 4 1 0 3 7 4 3 7 4 taken after `init` gives `z` = 0 0 0 0 0 0 0 0 1 0 0 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous restart of block alignment, window and tally |
| check | input | 1 | Symbol enable; the symbol is taken when high |
| sym | input | SYM_W | Current symbol |
| z | output | 1 | Block ended on the pattern this cycle |
| match_cnt | output | CNT_W | Matching blocks, modulo N (0 when COUNT_EN=0) |

## Verification
The bench builds the block with 3-bit symbols, K=3, the pattern 3,7,4 and N=4, with the tally enabled. K=3 makes every block exactly one window long, so occurrences that straddle a boundary by one or two symbols can be set apart from aligned ones. A tally depth of four lets a run of four matching blocks reach the wrap from 3 to 0. Pausing the enable mid-block with a pattern symbol on the bus, and restarting alignment while a window is half filled, cover the hold and restart paths.

// File: rtl/blkpat_pkg.sv
package blkpat_pkg;

    // Where the next accepted symbol lands inside its block.
    typedef enum logic [1:0] {
        SEQ_START = 2'd0,
        SEQ_BODY  = 2'd1,
        SEQ_CLOSE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/blkpat_block_seq.sv
module blkpat_block_seq
    import blkpat_pkg::*;
#(
    parameter int K = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic check,
    output logic eob
);
    localparam int POS_W = (K > 1) ? $clog2(K) : 1;
    localparam logic [POS_W-1:0] BODY_LAST = POS_W'((K > 2) ? K - 2 : 0);

    seq_state_t       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             take;

    assign take = check && !init;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_START;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (init) begin
            state_d = SEQ_START;                 // restart
            pos_d   = '0;
        end else if (take) begin
            unique case (state_q)
                SEQ_START: begin                 // open
                    pos_d = POS_W'(1);
                    if (K == 1) begin
                        state_d = SEQ_START;
                        pos_d   = '0;
                    end else if (K == 2) begin
                        state_d = SEQ_CLOSE;
                    end else begin
                        state_d = SEQ_BODY;
                    end
                end
                SEQ_BODY: begin                  // advance / near_end
                    pos_d = pos_q + POS_W'(1);
                    if (pos_q == BODY_LAST) state_d = SEQ_CLOSE;
                end
                SEQ_CLOSE: begin                 // wrap
                    state_d = SEQ_START;
                    pos_d   = '0;
                end
                default: begin
                    state_d = SEQ_START;
                    pos_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        eob = 1'b0;
        if (take) begin
            unique case (state_q)
                SEQ_START: eob = (K == 1);
                SEQ_BODY:  eob = 1'b0;
                SEQ_CLOSE: eob = 1'b1;
                default:   eob = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/blkpat_window.sv
module blkpat_window #(
    parameter int               SYM_W   = 3,
    parameter int               K       = 3,
    parameter logic [K*SYM_W-1:0] PATTERN = 9'b011_111_100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             check,
    input  logic [SYM_W-1:0] sym,
    output logic             hit
);
    logic [K-1:0] slot_ok;

    assign slot_ok[0] = (sym == PATTERN[SYM_W-1:0]);

    generate
        if (K > 1) begin : g_hist
            // hist_q[i] holds the symbol accepted i+1 steps ago
            logic [SYM_W-1:0] hist_q [K-1];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < K - 1; i++) hist_q[i] <= '0;
                end else if (init) begin
                    for (int i = 0; i < K - 1; i++) hist_q[i] <= '0;
                end else if (check) begin
                    hist_q[0] <= sym;
                    for (int i = 1; i < K - 1; i++) hist_q[i] <= hist_q[i-1];
                end
            end

            for (genvar g = 1; g < K; g++) begin : g_cmp
                assign slot_ok[g] = (hist_q[g-1] == PATTERN[g*SYM_W +: SYM_W]);
            end
        end
    endgenerate

    assign hit = &slot_ok;

endmodule

// File: rtl/blkpat_tally.sv
module blkpat_tally #(
    parameter int N = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                init,
    input  logic                                inc,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] cnt
);
    localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (init) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (cnt == TOP) ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/blkpat_recognizer.sv
module blkpat_recognizer #(
    parameter int                 SYM_W    = 3,
    parameter int                 K        = 3,
    parameter logic [K*SYM_W-1:0] PATTERN  = 9'b011_111_100,
    parameter int                 N        = 4,
    parameter bit                 COUNT_EN = 1'b1,
    localparam int                CNT_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             check,
    input  logic [SYM_W-1:0] sym,
    output logic             z,
    output logic [CNT_W-1:0] match_cnt
);
    logic eob;
    logic hit;

    blkpat_block_seq #(.K(K)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (init),
        .check (check),
        .eob   (eob)
    );

    blkpat_window #(.SYM_W(SYM_W), .K(K), .PATTERN(PATTERN)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (init),
        .check (check),
        .sym   (sym),
        .hit   (hit)
    );

    assign z = eob && hit;

    generate
        if (COUNT_EN) begin : g_tally
            blkpat_tally #(.N(N)) u_tally (
                .clk   (clk),
                .rst_n (rst_n),
                .init  (init),
                .inc   (z),
                .cnt   (match_cnt)
            );
        end else begin : g_no_tally
            assign match_cnt = '0;
        end
    endgenerate

endmodule

// File: rtl/blkpat_checker.sv
module blkpat_checker #(
    parameter int                 SYM_W    = 3,
    parameter int                 K        = 3,
    parameter logic [K*SYM_W-1:0] PATTERN  = 9'b011_111_100,
    parameter int                 N        = 4,
    parameter bit                 COUNT_EN = 1'b1,
    parameter int                 CNT_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init,
    input logic             check,
    input logic [SYM_W-1:0] sym,
    input logic             z,
    input logic [CNT_W-1:0] match_cnt
);
    localparam int PW = (K > 1) ? $clog2(K) : 1;

    // Independent count of accepted symbols within the block
    logic [PW-1:0]    seen_q;
    logic [CNT_W-1:0] cnt_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               seen_q <= '0;
        else if (init)            seen_q <= '0;
        else if (check)           seen_q <= (int'(seen_q) == K - 1) ? '0 : seen_q + PW'(1);
    end

    assign cnt_next = (int'(match_cnt) == N - 1) ? '0 : match_cnt + CNT_W'(1);

    a_r2_z_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        z |-> (int'(seen_q) == K - 1));

    a_r3_z_newest_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        z |-> (sym == PATTERN[SYM_W-1:0]));

    a_r5_quiet_without_check: assert property (@(posedge clk) disable iff (!rst_n)
        !check |-> !z);

    a_r6_init_blocks_z: assert property (@(posedge clk) disable iff (!rst_n)
        init |-> !z);

    a_r6_init_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (match_cnt == '0));

    a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!z && !init) |=> $stable(match_cnt));

    a_r8_count_steps_mod_n: assert property (@(posedge clk) disable iff (!rst_n)
        (COUNT_EN && z) |=> (match_cnt == $past(cnt_next)));

endmodule

bind blkpat_recognizer blkpat_checker #(
    .SYM_W(SYM_W), .K(K), .PATTERN(PATTERN), .N(N), .COUNT_EN(COUNT_EN), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .check     (check),
    .sym       (sym),
    .z         (z),
    .match_cnt (match_cnt)
);

// File: tb/test_blkpat_recognizer.sv
module test_blkpat_recognizer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init = 1'b0;
    logic       check = 1'b0;
    logic [2:0] sym = '0;
    logic       z;
    logic [1:0] match_cnt;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    blkpat_recognizer #(
        .SYM_W(3), .K(3), .PATTERN(9'b011_111_100), .N(4), .COUNT_EN(1'b1)
    ) i_blkpat_recognizer (
        .clk(clk), .rst_n(rst_n), .init(init), .check(check),
        .sym(sym), .z(z), .match_cnt(match_cnt)
    );

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: z actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic expect_cnt(input logic [1:0] exp, input string tag);
        n_checks++;
        if (match_cnt !== exp) begin
            n_fails++;
            $display("FAIL %s: match_cnt actual=%0d expected=%0d", tag, match_cnt, exp);
        end
    endtask

    // Drive one cycle, check z mid-cycle, then let the edge pass.
    task automatic step(input logic i_init, input logic i_chk, input logic [2:0] i_sym,
                        input logic exp_z, input string tag);
        @(negedge clk);
        init  = i_init;
        check = i_chk;
        sym   = i_sym;
        #2;
        expect_bit(z, exp_z, tag);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_bit(z, 1'b0, "R1 reset z");
        expect_cnt(2'd0, "R1 reset count");
        rst_n = 1'b1;
    endtask

    task automatic t_example();
        logic [2:0] xs [12] = '{3'd5, 3'd3, 3'd7, 3'd4, 3'd1, 3'd0, 3'd3, 3'd7, 3'd4, 3'd3, 3'd7, 3'd4};
        logic       ez [12] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1};
        step(1'b1, 1'b0, 3'd0, 1'b0, "R6 init");
        for (int i = 0; i < 12; i++)
            step(1'b0, 1'b1, xs[i], ez[i], $sformatf("R9 R3 R2 example t=%0d", i));
        expect_cnt(2'd2, "R7 example count");
    endtask

    task automatic t_straddle();
        logic [2:0] xs [6] = '{3'd0, 3'd3, 3'd7, 3'd4, 3'd1, 3'd1};
        logic [2:0] ys [6] = '{3'd1, 3'd1, 3'd3, 3'd7, 3'd4, 3'd0};
        step(1'b1, 1'b0, 3'd0, 1'b0, "R6 init");
        for (int i = 0; i < 6; i++)
            step(1'b0, 1'b1, xs[i], 1'b0, $sformatf("R4 straddle A t=%0d", i));
        for (int i = 0; i < 6; i++)
            step(1'b0, 1'b1, ys[i], 1'b0, $sformatf("R4 straddle B t=%0d", i));
        expect_cnt(2'd0, "R4 straddle count unchanged");
    endtask

    task automatic t_hold();
        step(1'b1, 1'b0, 3'd0, 1'b0, "R6 init");
        step(1'b0, 1'b1, 3'd3, 1'b0, "R5 pre 3");
        step(1'b0, 1'b1, 3'd7, 1'b0, "R5 pre 7");
        step(1'b0, 1'b0, 3'd4, 1'b0, "R5 paused with 4");
        step(1'b0, 1'b0, 3'd1, 1'b0, "R5 paused with 1");
        expect_cnt(2'd0, "R5 count held while paused");
        step(1'b0, 1'b1, 3'd4, 1'b1, "R5 resume closes block");
        expect_cnt(2'd1, "R7 count after resumed match");
    endtask

    task automatic t_reinit();
        step(1'b1, 1'b1, 3'd4, 1'b0, "R6 init drops symbol");
        expect_cnt(2'd0, "R6 init clears count");
        step(1'b0, 1'b1, 3'd3, 1'b0, "R6 fill 3");
        step(1'b0, 1'b1, 3'd7, 1'b0, "R6 fill 7");
        step(1'b1, 1'b1, 3'd4, 1'b0, "R6 init over match");
        step(1'b0, 1'b1, 3'd3, 1'b0, "R6 realigned 3");
        step(1'b0, 1'b1, 3'd7, 1'b0, "R6 realigned 7");
        step(1'b0, 1'b1, 3'd4, 1'b1, "R6 realigned 4");
        expect_cnt(2'd1, "R7 count after realigned match");
    endtask

    task automatic t_wrap();
        step(1'b1, 1'b0, 3'd0, 1'b0, "R6 init");
        for (int b = 0; b < 4; b++) begin
            step(1'b0, 1'b1, 3'd3, 1'b0, "R3 wrap 3");
            step(1'b0, 1'b1, 3'd7, 1'b0, "R3 wrap 7");
            step(1'b0, 1'b1, 3'd4, 1'b1, "R3 wrap 4");
            expect_cnt(2'((b + 1) % 4), $sformatf("R8 R7 count block %0d", b));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_example();
        t_straddle();
        t_hold();
        t_reinit();
        t_wrap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule